// File: doc/BRIEF.md
# Wake-Up Watchdog Reset Sequencer

This block paces a sleeping microcontroller. It drives a periodic wake-up square wave and an active-low reset line. Every wake-up cycle it expects the controller to answer with one falling edge on the watchdog input. The first such edge pulls wake-up low for the rest of that cycle. A cycle that ends with no answer leads to a reset pulse, then a restart delay, then a fresh cycle.

The reset line also follows a digital supply-good flag, which is synchronous to the clock. Reset stays low while the flag is false. After the flag goes true, reset stays low for one more unit. Every duration is a whole number of units, and one unit is `UNIT_CYCLES` clock cycles. The reset pulse is 1 unit long, the delay from reset release to the first wake-up is 4 units, and a wake-up cycle is 8 units.

Top module: `wake_watchdog_seq`

## Requirements
- R1: While `rst_ni` is low, `rst_no` and `wake_o` are both low.
- R2: When `pwr_good_i` is low at a rising clock edge, `rst_no` is low after that edge. It stays low for as long as the flag stays low.
- R3: When `pwr_good_i` is seen high in the holding state, `rst_no` rises exactly `UNIT_CYCLES` cycles after the first edge that sees the flag high.
- R4: After `rst_no` rises, `wake_o` stays low for 4 units and then rises. This starts a wake-up cycle.
- R5: Within a cycle with no early watchdog edge, `wake_o` is high for the first 4 units and low for the last 4 units. When the cycle holds a watchdog falling edge, the next cycle follows directly with no reset.
- R6: A falling edge on `wdi_i` during the high half makes `wake_o` low after the third rising clock edge following the change. `wake_o` then stays low until the cycle ends.
- R7: Only a 1-to-0 transition of `wdi_i` counts. A low level held across a whole cycle counts as a missed cycle.
- R8: Further falling edges in the same cycle have no effect. Wake-up stays low, reset stays high, and the cycle length is unchanged.
- R9: A cycle with no watchdog falling edge ends with `rst_no` going low for exactly 1 unit. The delay of R4 follows.
- R10: `wake_o` is low whenever `rst_no` is low.
- R11: A watchdog falling edge that arrives while `rst_no` is low, or during the restart delay, does not count toward the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wdi_i | input | 1 | Watchdog input from the controller, asynchronous, idle high |
| pwr_good_i | input | 1 | Supply-in-regulation flag, synchronous to `clk_i` |
| rst_no | output | 1 | Active-low reset to the controller |
| wake_o | output | 1 | Wake-up square wave |

## Verification
Both outputs are decoded from registered state, so each result is due a fixed number of edges after its cause. A watchdog change shows on `wake_o` three edges later, because of two synchronizer stages and the seen flag. A supply drop shows on `rst_no` one edge later. Reset release comes `UNIT_CYCLES + 1` edges after the supply flag rises, and each phase boundary falls an exact multiple of `UNIT_CYCLES` after the previous one. The directed checks count falling edges between a stimulus and the observed output change and compare that count with these figures. The random phase steps a cycle model in the bench on the same rising edges and compares both outputs at every falling edge.

// File: rtl/wws_pkg.sv
package wws_pkg;
  // phase lengths in units; the ratios are fixed by the block's behaviour
  localparam int unsigned RST_UNITS   = 1;
  localparam int unsigned START_UNITS = 4;
  localparam int unsigned CYCLE_UNITS = 8;
  localparam int unsigned HIGH_UNITS  = CYCLE_UNITS / 2;
  localparam int unsigned UNIT_W      = $clog2(CYCLE_UNITS);

  typedef logic [UNIT_W-1:0] unit_t;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,  // supply not good, reset low
    ST_RSTDLY = 2'd1,  // reset low, counting the reset width
    ST_START  = 2'd2,  // reset high, wake low, restart delay
    ST_RUN    = 2'd3   // wake-up cycles
  } seq_state_e;
endpackage

// File: rtl/wws_rst_sync.sv
module wws_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/wws_edge_det.sv
module wws_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  // synchronizer chain, reset to the idle-high level
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b1;
        else         sync_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b1;
    else         last_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/wws_timebase.sv
module wws_timebase
  import wws_pkg::*;
#(
  parameter int unsigned UNIT_CYCLES = 1000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  output logic  tick_o,
  output unit_t unit_o
);
  localparam int unsigned PRE_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_CYCLES - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  unit_t            unit_q, unit_d;

  assign tick_o = (pre_q == PRE_LAST);

  always_comb begin
    pre_d  = pre_q;
    unit_d = unit_q;
    if (clr_i) begin
      pre_d  = '0;
      unit_d = '0;
    end else if (tick_o) begin
      pre_d  = '0;
      unit_d = unit_t'(unit_q + 1'b1);
    end else begin
      pre_d  = PRE_W'(pre_q + 1'b1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else begin
      pre_q  <= pre_d;
      unit_q <= unit_d;
    end
  end

  assign unit_o = unit_q;
endmodule

// File: rtl/wws_fsm.sv
module wws_fsm
  import wws_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pwr_good_i,
  input  logic  wd_fall_i,
  input  logic  tick_i,
  input  unit_t unit_i,
  output logic  clr_o,
  output logic  rst_no,
  output logic  wake_o
);
  seq_state_e state_q, state_d;
  logic       seen_q, seen_d;
  logic       restart;
  logic       phase_end;
  unit_t      last_unit;

  always_comb begin
    case (state_q)
      ST_RSTDLY: last_unit = unit_t'(RST_UNITS - 1);
      ST_START:  last_unit = unit_t'(START_UNITS - 1);
      default:   last_unit = unit_t'(CYCLE_UNITS - 1);
    endcase
    phase_end = tick_i && (unit_i == last_unit);
  end

  always_comb begin
    state_d = state_q;
    seen_d  = 1'b0;
    restart = 1'b0;
    case (state_q)
      ST_HOLD: begin
        if (pwr_good_i) state_d = ST_RSTDLY;
      end
      ST_RSTDLY: begin
        if (phase_end) state_d = ST_START;
      end
      ST_START: begin
        if (phase_end) state_d = ST_RUN;
      end
      ST_RUN: begin
        seen_d = seen_q | wd_fall_i;
        if (phase_end) begin
          seen_d = 1'b0;
          if (seen_q || wd_fall_i) restart = 1'b1;
          else                     state_d = ST_RSTDLY;
        end
      end
      default: state_d = ST_HOLD;
    endcase
    if (!pwr_good_i) begin
      state_d = ST_HOLD;
      seen_d  = 1'b0;
    end
  end

  assign clr_o = (state_d != state_q) || restart || (state_q == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
    end
  end

  // Moore outputs decoded from registered state
  assign rst_no = (state_q == ST_START) || (state_q == ST_RUN);
  assign wake_o = (state_q == ST_RUN) && (unit_i < unit_t'(HIGH_UNITS)) && !seen_q;
endmodule

// File: rtl/wake_watchdog_seq.sv
module wake_watchdog_seq
  import wws_pkg::*;
#(
  parameter int unsigned UNIT_CYCLES = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdi_i,
  input  logic pwr_good_i,
  output logic rst_no,
  output logic wake_o
);
  logic  rst_int_n;
  logic  wd_fall;
  logic  tick;
  logic  clr;
  unit_t unit_cnt;

  wws_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  wws_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .async_i (wdi_i),
    .fall_o  (wd_fall)
  );

  wws_timebase #(.UNIT_CYCLES(UNIT_CYCLES)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .clr_i  (clr),
    .tick_o (tick),
    .unit_o (unit_cnt)
  );

  wws_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .pwr_good_i (pwr_good_i),
    .wd_fall_i  (wd_fall),
    .tick_i     (tick),
    .unit_i     (unit_cnt),
    .clr_o      (clr),
    .rst_no     (rst_no),
    .wake_o     (wake_o)
  );
endmodule

// File: rtl/wws_checker.sv
module wws_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_good_i,
  input logic rst_no,
  input logic wake_o
);
  assert_wake_in_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> !wake_o);

  assert_supply_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !rst_no);

  assert_release_needs_supply_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(pwr_good_i));

  assert_start_delay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> !wake_o);

  assert_miss_at_low_half_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rst_no) && $past(pwr_good_i)) |-> $past(!wake_o));

  assert_low_after_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(wake_o) && rst_no) |=> !wake_o);
endmodule

bind wake_watchdog_seq wws_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_good_i (pwr_good_i),
  .rst_no     (rst_no),
  .wake_o     (wake_o)
);

// File: tb/wake_watchdog_seq_tb.sv
module wake_watchdog_seq_tb;
  localparam int UC   = 6;
  localparam int HALF = 4 * UC;
  localparam int CYC  = 8 * UC;

  logic clk = 1'b0;
  logic rst_n, wdi, pwr;
  logic rst_no, wake_o;

  always #4 clk = ~clk;

  wake_watchdog_seq #(.UNIT_CYCLES(UC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wdi_i(wdi), .pwr_good_i(pwr),
    .rst_no(rst_no), .wake_o(wake_o)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle model built from the requirements
  int m_st, m_el;
  bit m_seen, m_s1, m_s2, m_s3;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_el <= 0; m_seen <= 1'b0;
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_s3 <= 1'b1;
    end else begin
      bit fall;
      fall = m_s3 & ~m_s2;
      m_s1 <= wdi; m_s2 <= m_s1; m_s3 <= m_s2;
      if (!pwr) begin
        m_st <= 0; m_el <= 0; m_seen <= 1'b0;
      end else begin
        case (m_st)
          0: begin m_st <= 1; m_el <= 0; end
          1: if (m_el == UC - 1) begin m_st <= 2; m_el <= 0; end else m_el <= m_el + 1;
          2: if (m_el == HALF - 1) begin m_st <= 3; m_el <= 0; m_seen <= 1'b0; end
             else m_el <= m_el + 1;
          default: begin
            if (m_el == CYC - 1) begin
              m_el <= 0; m_seen <= 1'b0;
              if (!(m_seen | fall)) m_st <= 1;
            end else begin
              m_el <= m_el + 1;
              m_seen <= m_seen | fall;
            end
          end
        endcase
      end
    end
  end

  function automatic int exp_rst(int st);
    return (st >= 2) ? 1 : 0;
  endfunction
  function automatic int exp_wake(int st, int el, bit seen);
    return (st == 3 && el < HALF && !seen) ? 1 : 0;
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2 R3 R9 reset", int'(rst_no), exp_rst(m_st));
      chk("R5 R6 R8 R10 R11 wake", int'(wake_o), exp_wake(m_st, m_el, m_seen));
    end
  end

  task automatic wait_rst(input logic v, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (rst_no !== v && n < 2000);
  endtask
  task automatic wait_wake(input logic v, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (wake_o !== v && n < 2000);
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int s;
    s = $urandom(32'h5eed);
    rst_n = 1'b0; wdi = 1'b1; pwr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset low", int'(rst_no), 0);
    chk("R1 wake low", int'(wake_o), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 reset while supply bad", int'(rst_no), 0);
    pwr = 1'b1;
    wait_rst(1'b1, n);
    chk("R3 release delay", n, UC + 1);
    wait_wake(1'b1, n);
    chk("R4 start delay", n, HALF);
    // R6 first edge, R8 second edge ignored
    repeat (2) @(negedge clk);
    wdi = 1'b0;
    wait_wake(1'b0, n);
    chk("R6 edge latency", n, 3);
    wdi = 1'b1;
    repeat (2) @(negedge clk);
    wdi = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 wake stays low", int'(wake_o), 0);
    chk("R8 reset stays high", int'(rst_no), 1);
    wait_wake(1'b1, n);
    chk("R8 cycle length", n, CYC - 11);
    // R5 full square wave, edge in low half
    wdi = 1'b1;
    wait_wake(1'b0, n);
    chk("R5 high half", n, HALF);
    wdi = 1'b0;
    wait_wake(1'b1, n);
    chk("R5 low half", n, HALF);
    chk("R5 no reset", int'(rst_no), 1);
    // R7 level low all cycle, R9 miss
    wait_rst(1'b0, n);
    chk("R7 R9 missed cycle", n, CYC);
    chk("R10 wake in reset", int'(wake_o), 0);
    // R11 edges during reset pulse and start delay
    wdi = 1'b1;
    repeat (2) @(negedge clk);
    wdi = 1'b0;
    wait_rst(1'b1, n);
    chk("R9 pulse width", n, UC - 2);
    wdi = 1'b1;
    repeat (2) @(negedge clk);
    wdi = 1'b0;
    wait_wake(1'b1, n);
    chk("R4 start delay again", n, HALF - 2);
    wait_rst(1'b0, n);
    chk("R11 early edges not counted", n, CYC);
    wdi = 1'b1;
    wait_rst(1'b1, n);
    wait_wake(1'b1, n);
    // R2 supply drop during run
    @(negedge clk);
    pwr = 1'b0;
    @(negedge clk);
    chk("R2 supply drop reset", int'(rst_no), 0);
    chk("R10 supply drop wake", int'(wake_o), 0);
    repeat (5) @(negedge clk);
    chk("R2 reset held", int'(rst_no), 0);
    pwr = 1'b1;
    wait_rst(1'b1, n);
    chk("R3 release after drop", n, UC + 1);
    // random phase against the model
    cmp_en = 1'b1;
    begin
      int mode = 0;
      int drop = 0;
      for (int i = 0; i < 20000; i++) begin
        @(negedge clk);
        if (i % 300 == 0) mode = $urandom % 4;
        case (mode)
          0: if ($urandom % 8 == 0) wdi = ~wdi;
          1: if ($urandom % 40 == 0) wdi = ~wdi;
          2: ;
          default: begin
            if ($urandom % 8 == 0) wdi = ~wdi;
            if (drop == 0 && $urandom % 200 == 0) drop = 1 + $urandom % 10;
          end
        endcase
        if (drop > 0) begin pwr = 1'b0; drop--; end
        else pwr = 1'b1;
      end
    end
    cmp_en = 1'b0;
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule